// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Sequencer

This block runs the bus-master half of the initialization handshake on a single open-drain data line. When it gets a start command while idle, it pulls the line low for the reset duration. It then lets the line float high again and checks once, at a fixed point, whether a slave device is holding it low. After that it waits out the rest of the release period and raises a one-clock completion strobe. The presence flag keeps its value until the next sequence begins.

Two speed grades are supported: regular and overdrive. Each grade has its own low time, release length and sampling point. The speed grade is latched when a start is accepted. All durations are counted in half-microsecond steps, derived from a prescaler set by the ticks-per-microsecond parameter. The regular low time is limited from above so that the low time plus an allowance for line rise time stays under 960 µs; this keeps other devices' interrupt signalling from being masked. It is also held at or above 480 µs, the length that puts every slave back to regular speed. The overdrive low time is held between 48 µs and 80 µs. The line input is expected to be synchronized to the clock already.

Top module: `owr_reset_seq`

## Requirements
- R1: While rst_ni is low, pull_o, busy_o, done_o and presence_o are all 0, and this takes effect without waiting for a clock edge.
- R2: A start_i seen in idle is accepted at that clock edge. pull_o (1 = drive the line low) goes high from that edge and stays high for the low time: 480 µs at regular speed (ovd_i = 0) and 64 µs at overdrive speed (ovd_i = 1) with default parameters. That is 1920 and 256 clocks at 4 ticks per µs. ovd_i is sampled only on the accepted start.
- R3: After the low time, pull_o stays 0 and busy_o stays 1 for the release period: 480 µs at regular speed, 48 µs at overdrive speed. busy_o then falls. pull_o is not asserted again within a sequence.
- R4: The line is sampled exactly once, 70 µs (regular) or 8.5 µs (overdrive) after release. presence_o becomes 1 if line_i is 0 (line low) at that clock and 0 if it is 1. presence_o is cleared when a start is accepted and otherwise keeps its value.
- R5: done_o is high for exactly one clock: the first clock in which busy_o is low after a sequence.
- R6: start_i while busy_o is high is ignored. It does not change any phase length, and it is not queued for later.
- R7: The regular low time is max(480, min(STD_LOW_US, 959 − RISE_US)) µs. The overdrive low time is OVD_LOW_US limited to the range 48..80 µs.
- R8: Pulling rst_ni low in the middle of a sequence releases the line and drops busy_o at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a reset/presence sequence |
| ovd_i | input | 1 | Speed grade for the requested sequence: 1 = overdrive |
| line_i | input | 1 | Synchronized line level, 1 = high |
| pull_o | output | 1 | Pull-down enable for the open-drain line |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock strobe at the end of the release period |
| presence_o | output | 1 | A slave held the line low at the sample point |

## Verification
The assertions check these rules on every clock:
- an accepted start asserts the pull-down on the next cycle;
- the pull-down occurs only while busy and never returns once released;
- done is a single cycle that directly follows busy;
- presence can only rise during the release phase and is cleared on every accepted start.

The actual phase lengths in clocks can only be shown by the bench scenarios, because each depends on the speed grade and the limiting of the parameters. The same holds for the presence result for slave responses that arrive early, late or not at all, and for the way a start arriving mid-sequence fails to disturb timing.

// File: rtl/owr_pkg.sv
package owr_pkg;

  localparam int unsigned STD_LOW_FLOOR_US  = 480;
  localparam int unsigned OVD_LOW_FLOOR_US  = 48;
  localparam int unsigned OVD_LOW_CEIL_US   = 80;
  localparam int unsigned LOW_RISE_LIMIT_US = 960;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOW     = 2'd1,
    ST_SENSE   = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  // floor wins when the window is empty
  function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
    int unsigned t;
    t = (v > hi) ? hi : v;
    return (t < lo) ? lo : t;
  endfunction

endpackage

// File: rtl/owr_half_us_strobe.sv
module owr_half_us_strobe #(
  parameter int unsigned HALF_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic strobe_o
);
  localparam int unsigned PW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF_CLKS - 1);

  logic [PW-1:0] cnt_q;

  assign strobe_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (strobe_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/owr_phase_timer.sv
module owr_phase_timer #(
  parameter int unsigned HALF_CLKS = 2,
  parameter int unsigned TW        = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] target_i,
  output logic          end_o
);
  logic          strobe;
  logic [TW-1:0] half_q;

  generate
    if (HALF_CLKS <= 1) begin : g_direct
      assign strobe = 1'b1;
    end else begin : g_prescale
      owr_half_us_strobe #(.HALF_CLKS(HALF_CLKS)) u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (clr_i),
        .strobe_o (strobe)
      );
    end
  endgenerate

  assign end_o = strobe && (half_q == target_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     half_q <= '0;
    else if (clr_i)  half_q <= '0;
    else if (strobe) half_q <= half_q + TW'(1);
  end
endmodule

// File: rtl/owr_seq_ctrl.sv
module owr_seq_ctrl
  import owr_pkg::*;
#(
  parameter int unsigned TW            = 12,
  parameter int unsigned STD_LOW_H     = 960,
  parameter int unsigned STD_SENSE_H   = 140,
  parameter int unsigned STD_RECOVER_H = 820,
  parameter int unsigned OVD_LOW_H     = 128,
  parameter int unsigned OVD_SENSE_H   = 17,
  parameter int unsigned OVD_RECOVER_H = 79
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ovd_i,
  input  logic          line_i,
  input  logic          phase_end_i,
  output logic          phase_clr_o,
  output logic [TW-1:0] target_o,
  output logic          pull_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          presence_o
);
  seq_state_e state_q, state_d;
  logic       ovd_q, done_q, pres_q;
  logic       accept, leave;

  assign accept      = (state_q == ST_IDLE) && start_i;
  assign leave       = (state_q != ST_IDLE) && phase_end_i;
  assign phase_clr_o = accept || leave;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_LOW;
      ST_LOW:     if (leave)  state_d = ST_SENSE;
      ST_SENSE:   if (leave)  state_d = ST_RECOVER;
      ST_RECOVER: if (leave)  state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_LOW:     target_o = ovd_q ? TW'(OVD_LOW_H)     : TW'(STD_LOW_H);
      ST_SENSE:   target_o = ovd_q ? TW'(OVD_SENSE_H)   : TW'(STD_SENSE_H);
      ST_RECOVER: target_o = ovd_q ? TW'(OVD_RECOVER_H) : TW'(STD_RECOVER_H);
      default:    target_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovd_q   <= 1'b0;
      done_q  <= 1'b0;
      pres_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RECOVER) && phase_end_i;
      if (accept) ovd_q <= ovd_i;
      if (accept)                                  pres_q <= 1'b0;
      else if ((state_q == ST_SENSE) && phase_end_i) pres_q <= ~line_i;
    end
  end

  assign pull_o     = (state_q == ST_LOW);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign presence_o = pres_q;
endmodule

// File: rtl/owr_reset_seq.sv
module owr_reset_seq
  import owr_pkg::*;
#(
  parameter int unsigned TICKS_PER_US     = 4,
  parameter int unsigned STD_LOW_US       = 480,
  parameter int unsigned OVD_LOW_US       = 64,
  parameter int unsigned RISE_US          = 20,
  parameter int unsigned STD_REL_US       = 480,
  parameter int unsigned OVD_REL_US       = 48,
  parameter int unsigned STD_SENSE_HALFUS = 140,
  parameter int unsigned OVD_SENSE_HALFUS = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ovd_i,
  input  logic line_i,
  output logic pull_o,
  output logic busy_o,
  output logic done_o,
  output logic presence_o
);
  localparam int unsigned HALF_CLKS  = (TICKS_PER_US >= 2) ? TICKS_PER_US / 2 : 1;
  localparam int unsigned STD_LOW_EF =
      clamp_u(STD_LOW_US, STD_LOW_FLOOR_US, LOW_RISE_LIMIT_US - 1 - RISE_US);
  localparam int unsigned OVD_LOW_EF =
      clamp_u(OVD_LOW_US, OVD_LOW_FLOOR_US, OVD_LOW_CEIL_US);
  localparam int unsigned STD_LOW_H  = 2 * STD_LOW_EF;
  localparam int unsigned OVD_LOW_H  = 2 * OVD_LOW_EF;
  localparam int unsigned STD_REC_H  = 2 * STD_REL_US - STD_SENSE_HALFUS;
  localparam int unsigned OVD_REC_H  = 2 * OVD_REL_US - OVD_SENSE_HALFUS;
  localparam int unsigned MAX_H      = 2 * (LOW_RISE_LIMIT_US + STD_REL_US + OVD_REL_US);
  localparam int unsigned TW         = $clog2(MAX_H + 1);

  logic          phase_clr, phase_end;
  logic [TW-1:0] target;

  owr_phase_timer #(.HALF_CLKS(HALF_CLKS), .TW(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (phase_clr),
    .target_i (target),
    .end_o    (phase_end)
  );

  owr_seq_ctrl #(
    .TW            (TW),
    .STD_LOW_H     (STD_LOW_H),
    .STD_SENSE_H   (STD_SENSE_HALFUS),
    .STD_RECOVER_H (STD_REC_H),
    .OVD_LOW_H     (OVD_LOW_H),
    .OVD_SENSE_H   (OVD_SENSE_HALFUS),
    .OVD_RECOVER_H (OVD_REC_H)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ovd_i       (ovd_i),
    .line_i      (line_i),
    .phase_end_i (phase_end),
    .phase_clr_o (phase_clr),
    .target_o    (target),
    .pull_o      (pull_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .presence_o  (presence_o)
  );
endmodule

// File: rtl/owr_reset_seq_chk.sv
module owr_reset_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pull_o,
  input logic busy_o,
  input logic done_o,
  input logic presence_o
);
  AST_START_PULLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (pull_o && busy_o)); // R2

  AST_PULL_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> busy_o); // R3

  AST_NO_RELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pull_o) |=> !pull_o); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R5

  AST_PRES_RISE_IN_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(presence_o) |-> (busy_o && !pull_o)); // R4

  AST_PRES_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> !presence_o); // R4
endmodule

bind owr_reset_seq owr_reset_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .pull_o     (pull_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .presence_o (presence_o)
);

// File: tb/owr_reset_seq_test.sv
module owr_reset_seq_test;
  localparam int TPU     = 4;
  localparam int STD_LO  = 480 * TPU;
  localparam int STD_REL = 480 * TPU;
  localparam int OVD_LO  = 64 * TPU;
  localparam int OVD_REL = 48 * TPU;

  typedef struct packed {
    logic        o;
    logic        s;
    logic [15:0] d;
    logic [15:0] w;
    logic        e;
  } vec_t;

  // speed, slave on, delay us, width us, expected presence
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 16'd0,  16'd0,   1'b0},
    '{1'b0, 1'b1, 16'd15, 16'd60,  1'b1},
    '{1'b0, 1'b1, 16'd60, 16'd240, 1'b1},
    '{1'b0, 1'b1, 16'd30, 16'd100, 1'b1},
    '{1'b1, 1'b0, 16'd0,  16'd0,   1'b0},
    '{1'b1, 1'b1, 16'd2,  16'd8,   1'b1},
    '{1'b1, 1'b1, 16'd6,  16'd24,  1'b1},
    '{1'b0, 1'b1, 16'd80, 16'd60,  1'b0},
    '{1'b1, 1'b1, 16'd9,  16'd8,   1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ovd = 1'b0, slv_pull = 1'b0;
  logic pull, busy, done, pres;
  logic line;
  logic start2 = 1'b0, ovd2 = 1'b0;
  logic pull2, busy2, done2, pres2, line2;

  assign line  = ~(pull | slv_pull);
  assign line2 = ~pull2;

  always #5 clk = ~clk;

  owr_reset_seq #(.TICKS_PER_US(TPU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ovd_i(ovd), .line_i(line),
    .pull_o(pull), .busy_o(busy), .done_o(done), .presence_o(pres)
  );

  owr_reset_seq #(.TICKS_PER_US(TPU), .STD_LOW_US(1000), .OVD_LOW_US(100), .RISE_US(40)) uut_clamp (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start2), .ovd_i(ovd2), .line_i(line2),
    .pull_o(pull2), .busy_o(busy2), .done_o(done2), .presence_o(pres2)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input bit o, input bit s, input int d, input int w,
                         input bit e, input int inj);
    int lo = 0, rel = 0, n = 0;
    fork
      begin
        @(negedge clk); start = 1'b1; ovd = o;
        @(negedge clk); start = 1'b0; ovd = ~o; // later ovd must not matter (R2)
        chk("R4", "presence cleared on start", int'(pres), 0);
        while (pull) begin
          lo++; n++; start = (n == inj); @(negedge clk);
        end
        while (busy && !pull) begin
          rel++; n++; start = (n == inj); @(negedge clk);
        end
        start = 1'b0;
        chk("R2", o ? "overdrive low clocks" : "regular low clocks", lo, o ? OVD_LO : STD_LO);
        chk("R3", o ? "overdrive release clocks" : "regular release clocks", rel, o ? OVD_REL : STD_REL);
        chk("R5", "done high after busy", int'(done), 1);
        chk("R4", "presence result", int'(pres), int'(e));
        @(negedge clk);
        chk("R5", "done one clock", int'(done), 0);
        chk("R6", "no queued restart", int'(busy), 0);
      end
      begin
        if (s) begin
          wait (pull);
          wait (!pull);
          repeat (d * TPU) @(negedge clk);
          slv_pull = 1'b1;
          repeat (w * TPU) @(negedge clk);
          slv_pull = 1'b0;
        end
      end
    join
  endtask

  task automatic run_clamp(input bit o, input int exp);
    int lo = 0;
    @(negedge clk); start2 = 1'b1; ovd2 = o;
    @(negedge clk); start2 = 1'b0;
    while (pull2) begin lo++; @(negedge clk); end
    chk("R7", o ? "overdrive low clamped" : "regular low clamped", lo, exp);
    while (busy2) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "pull in reset", int'(pull), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "presence in reset", int'(pres), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", int'(busy), 0);

    for (int i = 0; i < 9; i++)
      run_seq(VECS[i].o, VECS[i].s, int'(VECS[i].d), int'(VECS[i].w), VECS[i].e, 0);

    // start mid low, then mid release: ignored
    run_seq(1'b0, 1'b1, 20, 80, 1'b1, 100);
    run_seq(1'b1, 1'b0, 0, 0, 1'b0, OVD_LO + 60);

    // presence held while idle, cleared by next start
    run_seq(1'b1, 1'b1, 3, 10, 1'b1, 0);
    repeat (20) @(negedge clk);
    chk("R4", "presence held in idle", int'(pres), 1);
    run_seq(1'b0, 1'b0, 0, 0, 1'b0, 0);

    run_clamp(1'b0, 919 * TPU);
    run_clamp(1'b1, 80 * TPU);

    // reset in the middle of the low phase
    @(negedge clk); start = 1'b1; ovd = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", "line released on reset", int'(pull), 0);
    chk("R8", "busy dropped on reset", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8", "stays idle after reset", int'(busy), 0);
    run_seq(1'b1, 1'b1, 2, 8, 1'b1, 0);

    finish_run();
  end
endmodule